// File: doc/BRIEF.md
# Cascadable Serial Configuration Bit Streamer

This block is the read side of a bit-serial configuration store. After a power-up reset it holds a ready indicator low for a fixed number of clocks. It then presents one stored bit per clock on a data output with a separate driver enable. The host clock moves a single position counter one bit forward on each rising edge while the block is selected. A combined reset/output-enable pin turns the output driver on at one level. At the other level it sends the counter back to bit zero. A parameter picks which level of that pin is the reset level.

Several of these readers can be chained. When a reader has streamed its last bit, its chain-enable output goes low and selects the next device. That output then tracks the chip-enable input until the reset/output-enable pin reaches its reset level. After that it stays high until the whole store has been read again. A serial-enable input held low puts the block in programming mode, where reading is suspended and the chip-enable and reset/output-enable pins change nothing. The stored contents are fixed at elaboration.

Top module: `cfg_stream_reader`

## Requirements
- R1: `rdy_pull_o` is 1 (pulling the ready line low) while `rst` is high and for exactly `POR_CYCLES` rising edges after `rst` falls, then it is 0 and stays 0 until the next `rst`.
- R2: `data_drv_o` is 1 only when `ser_en_i` is 1, `rdy_pull_o` is 0, `ce_n_i` is 0 and `rst_oe_i` is not at the reset level; whenever `data_drv_o` is 0, `data_o` reads 0 (high impedance).
- R3: While the driver is enabled, `data_o` shows the stored bit at the current position, and each rising edge moves the position forward by one. Stored bit i equals the XOR of all bits of (i AND `PAT_MASK`). With the default mask 45, bits 0..5 read 0,1,0,1,1,0.
- R4: With `ser_en_i` at 1 and ready released, a rising edge with `rst_oe_i` at the reset level returns the position to bit 0, whatever `ce_n_i` is.
- R5: The reset level of `rst_oe_i` equals the parameter `RST_LEVEL` (1 by default). The opposite level enables the output.
- R6: A rising edge with `ce_n_i` at 1 and `rst_oe_i` at the enable level leaves the position unchanged, and reading resumes at the same bit.
- R7: After bit `DEPTH`-1 has been clocked out, the position holds at the end, and `data_o` is 1 whenever driven, until a reset level on `rst_oe_i`.
- R8: `ceo_n_o` goes low after the edge that consumes bit `DEPTH`-1. From then on it equals `ce_n_i` until the reset level is applied.
- R9: A rising edge with the reset level applied (with `ser_en_i` at 1 and ready released) sets `ceo_n_o` to 1. It stays 1 until all `DEPTH` bits have been read again.
- R10: With `ser_en_i` at 0, the driver is off and neither `ce_n_i` nor `rst_oe_i` moves or clears the position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock from the host; rising edges advance the bit position |
| rst | input | 1 | Synchronous active-high power-up reset |
| ser_en_i | input | 1 | 1 = read streaming, 0 = programming mode |
| ce_n_i | input | 1 | Active-low chip enable |
| rst_oe_i | input | 1 | Reset/output-enable pin; reset level set by `RST_LEVEL` |
| data_o | output | 1 | Serial data bit; 0 while not driven |
| data_drv_o | output | 1 | 1 = data driver on, 0 = high impedance |
| ceo_n_o | output | 1 | Active-low chain enable for the next device |
| rdy_pull_o | output | 1 | 1 = ready line actively pulled low, 0 = released |

## Verification
The bench stops the clock-enabled stream with chip-enable high and then resumes it. A design that kept counting while deselected would resume several bits further on. A reset level applied while chip-enable is high must still clear the position, and a reader that tied the clear to selection would restart from the wrong bit. The bench also streams the whole store and then keeps clocking past its end. This exposes a counter that wraps back to bit zero, or a chain output that does not follow chip-enable. A chain output that goes low again right after a restart, instead of after a complete second pass, is caught too. A second instance with the opposite reset level checks that the level is taken from the parameter and not fixed.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;

    // Chain output phase: quiet (high) or passing chip enable through
    typedef enum logic {
        CH_QUIET = 1'b0,
        CH_PASS  = 1'b1
    } chain_state_e;

    // Decoded pin conditions for one cycle
    typedef struct packed {
        logic sel;   // streaming mode, ready, chip enabled
        logic oe;    // reset/oe pin at its enable level
        logic adv;   // advance this edge
        logic clr;   // clear position this edge
    } rd_ctl_t;

    // Stored content: XOR reduction of the index masked by a pattern
    function automatic logic cfg_bit(input int unsigned idx, input int unsigned mask);
        return ^(idx & mask);
    endfunction

endpackage

// File: rtl/por_timer.sv
module por_timer #(
    parameter int POR_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    output logic hold_o
);
    localparam int PW = $clog2(POR_CYCLES + 1);

    logic [PW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= PW'(POR_CYCLES);
        end else if (left_q != '0) begin
            left_q <= left_q - PW'(1);
        end
    end

    assign hold_o = (left_q != '0);
endmodule

// File: rtl/bit_position.sv
module bit_position #(
    parameter int DEPTH = 64,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv_i,
    input  logic          clr_i,
    output logic [AW-1:0] pos_o,
    output logic          done_o,
    output logic          last_hit_o
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [AW-1:0] pos_q;
    logic          done_q;

    // Final bit consumed on this edge
    assign last_hit_o = adv_i && !clr_i && !done_q && (pos_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            pos_q  <= '0;
            done_q <= 1'b0;
        end else if (adv_i && !done_q) begin
            if (pos_q == LAST) begin
                done_q <= 1'b1;
            end else begin
                pos_q <= pos_q + AW'(1);
            end
        end
    end

    assign pos_o  = pos_q;
    assign done_o = done_q;
endmodule

// File: rtl/bit_store.sv
module bit_store #(
    parameter int          DEPTH    = 64,
    parameter int unsigned PAT_MASK = 45,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [AW-1:0] pos_i,
    output logic          bit_o
);
    import cfg_stream_pkg::*;

    logic [DEPTH-1:0] cells;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        assign cells[g] = cfg_bit(g, PAT_MASK);
    end

    assign bit_o = cells[pos_i];
endmodule

// File: rtl/chain_ctl.sv
module chain_ctl
    import cfg_stream_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic last_hit_i,
    input  logic clr_i,
    input  logic ce_n_i,
    output logic ceo_n_o
);
    chain_state_e st_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            st_q <= CH_QUIET;
        end else if (last_hit_i) begin
            st_q <= CH_PASS;
        end
    end

    assign ceo_n_o = (st_q == CH_PASS) ? ce_n_i : 1'b1;
endmodule

// File: rtl/cfg_stream_reader.sv
module cfg_stream_reader
    import cfg_stream_pkg::*;
#(
    parameter int          DEPTH      = 64,
    parameter int          POR_CYCLES = 8,
    parameter int unsigned PAT_MASK   = 45,
    parameter bit          RST_LEVEL  = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic ser_en_i,
    input  logic ce_n_i,
    input  logic rst_oe_i,
    output logic data_o,
    output logic data_drv_o,
    output logic ceo_n_o,
    output logic rdy_pull_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic          por_hold;
    logic [AW-1:0] cnt_q;
    logic          done_q;
    logic          last_hit;
    logic          store_bit;
    rd_ctl_t       ctl;

    por_timer #(.POR_CYCLES(POR_CYCLES)) u_por (
        .clk    (clk),
        .rst    (rst),
        .hold_o (por_hold)
    );

    always_comb begin
        ctl.sel = ser_en_i && !ce_n_i && !por_hold;
        ctl.oe  = (rst_oe_i != RST_LEVEL);
        ctl.adv = ctl.sel && ctl.oe;
        ctl.clr = ser_en_i && !por_hold && !ctl.oe;
    end

    bit_position #(.DEPTH(DEPTH)) u_pos (
        .clk        (clk),
        .rst        (rst),
        .adv_i      (ctl.adv),
        .clr_i      (ctl.clr),
        .pos_o      (cnt_q),
        .done_o     (done_q),
        .last_hit_o (last_hit)
    );

    bit_store #(.DEPTH(DEPTH), .PAT_MASK(PAT_MASK)) u_store (
        .pos_i (cnt_q),
        .bit_o (store_bit)
    );

    chain_ctl u_chain (
        .clk        (clk),
        .rst        (rst),
        .last_hit_i (last_hit),
        .clr_i      (ctl.clr),
        .ce_n_i     (ce_n_i),
        .ceo_n_o    (ceo_n_o)
    );

    assign data_drv_o = ctl.adv;
    assign data_o     = ctl.adv && (done_q || store_bit);
    assign rdy_pull_o = por_hold;
endmodule

// File: rtl/cfg_stream_reader_chk.sv
module cfg_stream_reader_chk #(
    parameter int AW        = 6,
    parameter int DEPTH     = 64,
    parameter bit RST_LEVEL = 1'b1
) (
    input logic          clk,
    input logic          rst,
    input logic          ser_en_i,
    input logic          ce_n_i,
    input logic          rst_oe_i,
    input logic          data_o,
    input logic          data_drv_o,
    input logic          ceo_n_o,
    input logic          rdy_pull_o,
    input logic [AW-1:0] cnt_q,
    input logic          done_q
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    assert_ready_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !rdy_pull_o |=> !rdy_pull_o);

    assert_no_drive_in_por_R2: assert property (@(posedge clk) disable iff (rst)
        rdy_pull_o |-> !data_drv_o);

    assert_step_R3: assert property (@(posedge clk) disable iff (rst)
        (data_drv_o && !done_q && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + AW'(1)));

    assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (ser_en_i && !rdy_pull_o && rst_oe_i == RST_LEVEL) |=> (cnt_q == '0 && !done_q));

    assert_freeze_R6: assert property (@(posedge clk) disable iff (rst)
        (ce_n_i && rst_oe_i != RST_LEVEL) |=> ($stable(cnt_q) && $stable(done_q)));

    assert_end_high_R7: assert property (@(posedge clk) disable iff (rst)
        (done_q && data_drv_o) |-> data_o);

    assert_ceo_tracks_R8: assert property (@(posedge clk) disable iff (rst)
        !ceo_n_o |-> !ce_n_i);

    assert_ceo_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (ser_en_i && !rdy_pull_o && rst_oe_i == RST_LEVEL) |=> ceo_n_o);

    assert_prog_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        !ser_en_i |=> ($stable(cnt_q) && $stable(done_q)));

    assert_prog_no_drive_R10: assert property (@(posedge clk) disable iff (rst)
        !ser_en_i |-> !data_drv_o);
endmodule

bind cfg_stream_reader cfg_stream_reader_chk #(
    .AW        (AW),
    .DEPTH     (DEPTH),
    .RST_LEVEL (RST_LEVEL)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ser_en_i   (ser_en_i),
    .ce_n_i     (ce_n_i),
    .rst_oe_i   (rst_oe_i),
    .data_o     (data_o),
    .data_drv_o (data_drv_o),
    .ceo_n_o    (ceo_n_o),
    .rdy_pull_o (rdy_pull_o),
    .cnt_q      (cnt_q),
    .done_q     (done_q)
);

// File: tb/tb_cfg_stream_reader.sv
module tb_cfg_stream_reader;
    localparam int DEPTH = 64;
    localparam int POR   = 8;
    localparam int MASK  = 45;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_en, ce_n, pin;
    logic data, drv, ceo_n, rdy_pull;
    logic lo_ser, lo_ce_n, lo_pin;
    logic lo_data, lo_drv, lo_ceo_n, lo_rdy;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    cfg_stream_reader #(.DEPTH(DEPTH), .POR_CYCLES(POR), .PAT_MASK(MASK), .RST_LEVEL(1'b1)) dut (
        .clk(clk), .rst(rst), .ser_en_i(ser_en), .ce_n_i(ce_n), .rst_oe_i(pin),
        .data_o(data), .data_drv_o(drv), .ceo_n_o(ceo_n), .rdy_pull_o(rdy_pull)
    );

    cfg_stream_reader #(.DEPTH(DEPTH), .POR_CYCLES(POR), .PAT_MASK(MASK), .RST_LEVEL(1'b0)) dut_lo (
        .clk(clk), .rst(rst), .ser_en_i(lo_ser), .ce_n_i(lo_ce_n), .rst_oe_i(lo_pin),
        .data_o(lo_data), .data_drv_o(lo_drv), .ceo_n_o(lo_ceo_n), .rdy_pull_o(lo_rdy)
    );

    function automatic logic ref_bit(input int i);
        return ^(i & MASK);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // {ser_en, ce_n, pin, exp_drv, exp_idx[5:0]}; RST_LEVEL = 1
    localparam logic [9:0] VEC [14] = '{
        {4'b1001, 6'd0}, {4'b1001, 6'd1}, {4'b1001, 6'd2},
        {4'b1100, 6'd0}, {4'b1100, 6'd0}, {4'b1001, 6'd3},
        {4'b0000, 6'd0}, {4'b0010, 6'd0}, {4'b1001, 6'd4},
        {4'b1110, 6'd0}, {4'b1001, 6'd0}, {4'b1001, 6'd1},
        {4'b1010, 6'd0}, {4'b1001, 6'd0}
    };

    task automatic drive(input logic s, input logic c, input logic p);
        @(negedge clk);
        ser_en = s; ce_n = c; pin = p;
        #2;
    endtask

    initial begin
        ser_en = 1'b1; ce_n = 1'b0; pin = 1'b0;
        lo_ser = 1'b1; lo_ce_n = 1'b0; lo_pin = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        // Reset state
        chk(rdy_pull == 1'b1, "R1 ready pulled in reset", rdy_pull, 1);
        chk(drv == 1'b0 && data == 1'b0, "R2 no drive in reset", drv, 0);
        chk(ceo_n == 1'b1, "R8 chain high in reset", ceo_n, 1);
        @(negedge clk);
        rst = 1'b0;
        repeat (POR - 1) @(posedge clk);
        #2;
        chk(rdy_pull == 1'b1, "R1 ready still pulled", rdy_pull, 1);
        chk(drv == 1'b0, "R2 no drive before ready", drv, 0);
        @(posedge clk);
        #2;
        chk(rdy_pull == 1'b0, "R1 ready released", rdy_pull, 0);

        // Vector table walk
        for (int v = 0; v < 14; v++) begin
            drive(VEC[v][9], VEC[v][8], VEC[v][7]);
            chk(drv == VEC[v][6], $sformatf("R2 R6 R10 drive vec %0d", v), drv, VEC[v][6]);
            if (VEC[v][6])
                chk(data == ref_bit(int'(VEC[v][5:0])), $sformatf("R3 R4 data vec %0d", v),
                    data, ref_bit(int'(VEC[v][5:0])));
            else
                chk(data == 1'b0, $sformatf("R2 idle data vec %0d", v), data, 0);
        end

        // Full read to the end of store
        drive(1'b1, 1'b0, 1'b1);
        for (int i = 0; i < DEPTH; i++) begin
            drive(1'b1, 1'b0, 1'b0);
            chk(data == ref_bit(i), $sformatf("R3 stream bit %0d", i), data, ref_bit(i));
            chk(ceo_n == 1'b1, $sformatf("R8 chain high at bit %0d", i), ceo_n, 1);
        end
        drive(1'b1, 1'b0, 1'b0);
        chk(ceo_n == 1'b0, "R8 chain low after last bit", ceo_n, 0);
        chk(data == 1'b1 && drv == 1'b1, "R7 data high past end", data, 1);
        drive(1'b1, 1'b0, 1'b0);
        chk(data == 1'b1, "R7 holds at end", data, 1);
        chk(ceo_n == 1'b0, "R8 chain stays low", ceo_n, 0);
        drive(1'b1, 1'b1, 1'b0);
        chk(ceo_n == 1'b1, "R8 chain follows ce high", ceo_n, 1);
        drive(1'b1, 1'b0, 1'b0);
        chk(ceo_n == 1'b0, "R8 chain follows ce low", ceo_n, 0);
        chk(data == 1'b1, "R7 still at end after freeze", data, 1);
        drive(1'b1, 1'b0, 1'b1);
        drive(1'b1, 1'b0, 1'b0);
        chk(ceo_n == 1'b1, "R9 chain high after reset level", ceo_n, 1);
        chk(data == ref_bit(0), "R4 restart at bit 0", data, ref_bit(0));
        for (int i = 0; i < DEPTH - 1; i++) drive(1'b1, 1'b0, 1'b0);
        chk(ceo_n == 1'b1, "R9 chain high before full re-read", ceo_n, 1);
        chk(data == ref_bit(DEPTH - 1), "R3 last bit on re-read", data, ref_bit(DEPTH - 1));
        drive(1'b1, 1'b0, 1'b0);
        chk(ceo_n == 1'b0, "R9 chain low after full re-read", ceo_n, 0);

        // Opposite reset level on second instance
        @(negedge clk);
        lo_pin = 1'b1;
        #2;
        chk(lo_drv == 1'b1 && lo_data == ref_bit(0), "R5 high level enables", lo_data, ref_bit(0));
        repeat (3) @(posedge clk);
        #2;
        chk(lo_data == ref_bit(3), "R5 advance with high level", lo_data, ref_bit(3));
        @(negedge clk);
        lo_pin = 1'b0;
        #2;
        chk(lo_drv == 1'b0, "R5 low level disables", lo_drv, 0);
        @(negedge clk);
        lo_pin = 1'b1;
        #2;
        chk(lo_data == ref_bit(0), "R5 low level resets", lo_data, ref_bit(0));
        chk(lo_ceo_n == 1'b1, "R9 second instance chain high", lo_ceo_n, 1);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule